// File: doc/BRIEF.md
# Serial Command Frame Decoder for a Voltage-Output Converter

This block sits between a three-wire, write-only serial port (active-low select, serial clock, data in) and an 8-bit voltage-output converter. A system clock samples the serial wires through synchronizers and assembles each 16-bit command word. When the select line returns high, the word is checked and decoded, and the block updates a pair of registers. The staging register holds a prepared code. The output register holds the code the converter is currently driving.

Commands can fill only the staging register, copy the staging register to the output register, or load both registers at once. This lets a host prepare a value and later apply it at a chosen moment. Power-mode requests, with a 2-bit reference selection, go to a separate power controller as one-cycle strobes. Any command that writes the output register also sends a one-cycle wake strobe. Frames of the wrong length, no-operation words and reserved command codes change nothing. A well-sized frame with nonzero trailing bits raises a one-cycle error pulse and is otherwise dropped.

Top module: `dacfr_top`

## Requirements
- R1: A frame is 16 bits taken most significant bit first, one bit on each rising serial clock edge while select is low. Bits [15:12] form the command, bits [11:4] form the data and bits [3:0] are trailing bits.
- R2: After reset, input_code and dac_code are both 0, and no strobe or error pulse has been given.
- R3: Command 4'b0001 loads the frame data into input_code. dac_code is unchanged and no wake strobe is given.
- R4: Command 4'b1000 copies input_code into dac_code and ignores the frame data. input_code is unchanged.
- R5: Commands 4'b1001 and 4'b1111 load the frame data into both input_code and dac_code.
- R6: Command 4'b0000 and the reserved commands 4'b0010 to 4'b0111, 4'b1010 and 4'b1011 change no register and give no strobe.
- R7: A frame in which the number of clocked bits is not exactly 16 when select rises is discarded: no register changes, and no strobe or error pulse is given.
- R8: A 16-bit frame with nonzero trailing bits changes no register and gives one frame_err pulse lasting one cycle.
- R9: Commands 4'b1100, 4'b1101 and 4'b1110 give one pm_strobe pulse lasting one cycle. pm_req is 0, 1 or 2 respectively, and ref_sel takes data bits D7:D6. input_code and dac_code are unchanged.
- R10: wake_strobe pulses for one cycle on every command that writes dac_code (4'b1000, 4'b1001, 4'b1111) and on no other command.
- R11: A command takes effect only after select rises. With 16 bits clocked in and select still low, no register has changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial wires |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sclk | input | 1 | Serial clock; data is taken on its rising edge |
| spi_mosi | input | 1 | Serial data in |
| input_code | output | 8 | Staging register contents |
| dac_code | output | 8 | Code driven to the converter |
| wake_strobe | output | 1 | One-cycle pulse when dac_code is written |
| pm_strobe | output | 1 | One-cycle power-mode request |
| pm_req | output | 2 | Requested mode: 0 standby, 1 normal, 2 shutdown |
| ref_sel | output | 2 | Reference selection sent with pm_strobe |
| frame_err | output | 1 | One-cycle pulse for a frame with nonzero trailing bits |

## Verification
The data value 0x3A is not a palindrome in bit order, so a reversed shift would show up in R1 and R3. Each register-writing command is given a data field different from the current register values, which separates "copy from staging" from "load from frame". Frames of 15 and 17 bits, frames with a nonzero trailing nibble, and reserved command codes are each paired with data that would be visible if accepted. A frame held open after its 16th bit tests R11. Each power command uses its own reference bits, so a mix-up between the mode field and the reference field is visible.

// File: rtl/dacfr_pkg.sv
package dacfr_pkg;

   localparam int CMD_W = 4;

   typedef enum logic [CMD_W-1:0] {
      CMD_NOP       = 4'b0000,
      CMD_STAGE     = 4'b0001,
      CMD_APPLY     = 4'b1000,
      CMD_BOTH      = 4'b1001,
      CMD_PWR_STBY  = 4'b1100,
      CMD_PWR_RUN   = 4'b1101,
      CMD_PWR_OFF   = 4'b1110,
      CMD_BOTH_ALT  = 4'b1111
   } cmd_e;

   typedef enum logic [1:0] {
      PM_STANDBY  = 2'd0,
      PM_NORMAL   = 2'd1,
      PM_SHUTDOWN = 2'd2
   } pm_req_e;

   typedef struct packed {
      logic    ld_stage;
      logic    ld_out_frame;
      logic    ld_out_stage;
      logic    pm_vld;
      pm_req_e pm_req;
      logic    err;
   } act_t;

endpackage

// File: rtl/dacfr_serial_rx.sv
module dacfr_serial_rx #(
   parameter int FRAME_W     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_n_i,
   input  logic               sclk_i,
   input  logic               sdi_i,
   output logic               frame_stb_o,
   output logic [FRAME_W-1:0] frame_o,
   output logic               len_ok_o
);
   localparam int CNT_W = $clog2(FRAME_W + 2);
   localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [2:0] IDLE_PINS = 3'b100;

   logic [2:0] pins_s;
   logic       cs_s, sclk_s, sdi_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign pins_s = {cs_n_i, sclk_i, sdi_i};
      end else begin : g_sync
         logic [SYNC_STAGES-1:0][2:0] pipe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) pipe_q[i] <= IDLE_PINS;
            end else begin
               pipe_q[0] <= {cs_n_i, sclk_i, sdi_i};
               for (int i = 1; i < SYNC_STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            end
         end
         assign pins_s = pipe_q[SYNC_STAGES-1];
      end
   endgenerate

   assign {cs_s, sclk_s, sdi_s} = pins_s;

   logic               cs_q, sclk_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [FRAME_W-1:0] shreg_q;
   logic               sclk_rise, cs_rise;

   assign sclk_rise = sclk_s & ~sclk_q;
   assign cs_rise   = cs_s & ~cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q        <= 1'b1;
         sclk_q      <= 1'b0;
         cnt_q       <= '0;
         shreg_q     <= '0;
         frame_stb_o <= 1'b0;
         frame_o     <= '0;
         len_ok_o    <= 1'b0;
      end else begin
         cs_q        <= cs_s;
         sclk_q      <= sclk_s;
         frame_stb_o <= 1'b0;
         if (cs_s) begin
            cnt_q <= '0;
         end else if (sclk_rise) begin
            shreg_q <= {shreg_q[FRAME_W-2:0], sdi_s};
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
         end
         if (cs_rise) begin
            frame_stb_o <= 1'b1;
            frame_o     <= shreg_q;
            len_ok_o    <= (cnt_q == CNT_FULL);
         end
      end
   end
endmodule

// File: rtl/dacfr_decode.sv
module dacfr_decode
   import dacfr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SUB_W  = 4,
   localparam int FRAME_W = CMD_W + DATA_W + SUB_W
) (
   input  logic               frame_stb_i,
   input  logic               len_ok_i,
   input  logic [FRAME_W-1:0] frame_i,
   output act_t               act_o,
   output logic [DATA_W-1:0]  data_o,
   output logic [1:0]         ref_o
);
   logic [CMD_W-1:0] cmd;
   logic [SUB_W-1:0] sub;

   assign cmd    = frame_i[FRAME_W-1 -: CMD_W];
   assign data_o = frame_i[SUB_W +: DATA_W];
   assign sub    = frame_i[SUB_W-1:0];
   assign ref_o  = data_o[DATA_W-1 -: 2];

   always_comb begin
      act_o = '0;
      if (frame_stb_i && len_ok_i) begin
         if (sub != '0) begin
            act_o.err = 1'b1;
         end else begin
            unique case (cmd)
               CMD_STAGE: act_o.ld_stage = 1'b1;
               CMD_APPLY: act_o.ld_out_stage = 1'b1;
               CMD_BOTH, CMD_BOTH_ALT: begin
                  act_o.ld_stage     = 1'b1;
                  act_o.ld_out_frame = 1'b1;
               end
               CMD_PWR_STBY: begin
                  act_o.pm_vld = 1'b1;
                  act_o.pm_req = PM_STANDBY;
               end
               CMD_PWR_RUN: begin
                  act_o.pm_vld = 1'b1;
                  act_o.pm_req = PM_NORMAL;
               end
               CMD_PWR_OFF: begin
                  act_o.pm_vld = 1'b1;
                  act_o.pm_req = PM_SHUTDOWN;
               end
               default: act_o = '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/dacfr_regs.sv
module dacfr_regs
   import dacfr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  act_t              act_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [1:0]        ref_i,
   output logic [DATA_W-1:0] stage_o,
   output logic [DATA_W-1:0] out_o,
   output logic              wake_o,
   output logic              pm_stb_o,
   output logic [1:0]        pm_req_o,
   output logic [1:0]        ref_o,
   output logic              err_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_o  <= '0;
         out_o    <= '0;
         wake_o   <= 1'b0;
         pm_stb_o <= 1'b0;
         pm_req_o <= 2'd0;
         ref_o    <= 2'd0;
         err_o    <= 1'b0;
      end else begin
         if (act_i.ld_stage) stage_o <= data_i;
         if (act_i.ld_out_frame)      out_o <= data_i;
         else if (act_i.ld_out_stage) out_o <= stage_o;
         wake_o   <= act_i.ld_out_frame | act_i.ld_out_stage;
         pm_stb_o <= act_i.pm_vld;
         if (act_i.pm_vld) begin
            pm_req_o <= act_i.pm_req;
            ref_o    <= ref_i;
         end
         err_o <= act_i.err;
      end
   end
endmodule

// File: rtl/dacfr_top.sv
module dacfr_top
   import dacfr_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SUB_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_cs_n,
   input  logic              spi_sclk,
   input  logic              spi_mosi,
   output logic [DATA_W-1:0] input_code,
   output logic [DATA_W-1:0] dac_code,
   output logic              wake_strobe,
   output logic              pm_strobe,
   output logic [1:0]        pm_req,
   output logic [1:0]        ref_sel,
   output logic              frame_err
);
   localparam int FRAME_W = CMD_W + DATA_W + SUB_W;

   generate
      if (DATA_W < 2)      $error("DATA_W must hold the two reference bits");
      if (SUB_W < 1)       $error("SUB_W must be at least one");
      if (SYNC_STAGES < 0) $error("SYNC_STAGES must not be negative");
   endgenerate

   logic               frame_stb;
   logic               len_ok;
   logic [FRAME_W-1:0] frame;
   act_t               act;
   logic [DATA_W-1:0]  data;
   logic [1:0]         ref_bits;

   dacfr_serial_rx #(.FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES)) rx_i (
      .clk(clk), .rst_n(rst_n),
      .cs_n_i(spi_cs_n), .sclk_i(spi_sclk), .sdi_i(spi_mosi),
      .frame_stb_o(frame_stb), .frame_o(frame), .len_ok_o(len_ok)
   );

   dacfr_decode #(.DATA_W(DATA_W), .SUB_W(SUB_W)) dec_i (
      .frame_stb_i(frame_stb), .len_ok_i(len_ok), .frame_i(frame),
      .act_o(act), .data_o(data), .ref_o(ref_bits)
   );

   dacfr_regs #(.DATA_W(DATA_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .act_i(act), .data_i(data), .ref_i(ref_bits),
      .stage_o(input_code), .out_o(dac_code), .wake_o(wake_strobe),
      .pm_stb_o(pm_strobe), .pm_req_o(pm_req), .ref_o(ref_sel),
      .err_o(frame_err)
   );
endmodule

// File: rtl/dacfr_chk.sv
module dacfr_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_stb,
   input logic [DATA_W-1:0] input_code,
   input logic [DATA_W-1:0] dac_code,
   input logic              wake_strobe,
   input logic              pm_strobe,
   input logic [1:0]        pm_req,
   input logic              frame_err
);
   // R11
   stage_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(input_code) |-> $past(frame_stb));

   // R10
   out_change_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dac_code) |-> wake_strobe);

   // R10
   wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_strobe |=> !wake_strobe);

   // R9
   pm_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pm_strobe |=> !pm_strobe);

   // R9
   pm_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pm_strobe |-> pm_req != 2'd3);

   // R8
   err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> (!pm_strobe && !wake_strobe && $stable(input_code)));
endmodule

bind dacfr_top dacfr_chk #(.DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
   .input_code(input_code), .dac_code(dac_code),
   .wake_strobe(wake_strobe), .pm_strobe(pm_strobe),
   .pm_req(pm_req), .frame_err(frame_err)
);

// File: tb/dacfr_top_tb_top.sv
module dacfr_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sclk = 1'b0;
   logic       mosi = 1'b0;
   logic [7:0] input_code, dac_code;
   logic       wake_strobe, pm_strobe, frame_err;
   logic [1:0] pm_req, ref_sel;

   int n_cmp = 0;
   int n_bad = 0;
   int n_wake = 0, n_pm = 0, n_err = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dacfr_top dut_i (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk),
      .spi_mosi(mosi), .input_code(input_code), .dac_code(dac_code),
      .wake_strobe(wake_strobe), .pm_strobe(pm_strobe), .pm_req(pm_req),
      .ref_sel(ref_sel), .frame_err(frame_err)
   );

   always @(negedge clk) begin
      if (wake_strobe) n_wake++;
      if (pm_strobe)   n_pm++;
      if (frame_err)   n_err++;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clr_counts();
      n_wake = 0; n_pm = 0; n_err = 0;
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic open_frame();
      cs_n = 1'b0;
      wait_clk(4);
   endtask

   task automatic shift_bits(input logic [31:0] w, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         mosi = w[i];
         wait_clk(4);
         sclk = 1'b1;
         wait_clk(4);
         sclk = 1'b0;
      end
   endtask

   task automatic close_frame();
      wait_clk(4);
      cs_n = 1'b1;
      wait_clk(14);
   endtask

   task automatic send(input logic [3:0] c, input logic [7:0] d, input logic [3:0] s);
      open_frame();
      shift_bits({16'h0, c, d, s}, 16);
      close_frame();
   endtask

   task automatic t_reset();
      chk("R2 input_code", input_code, 0);
      chk("R2 dac_code", dac_code, 0);
      chk("R2 strobes", n_wake + n_pm + n_err, 0);
   endtask

   task automatic t_stage();
      clr_counts();
      send(4'b0001, 8'h3A, 4'h0);
      chk("R1/R3 input_code msb first", input_code, 8'h3A);
      chk("R3 dac_code kept", dac_code, 0);
      chk("R3 no wake", n_wake, 0);
   endtask

   task automatic t_apply();
      clr_counts();
      send(4'b1000, 8'hC5, 4'h0);
      chk("R4 dac_code from stage", dac_code, 8'h3A);
      chk("R4 input_code kept", input_code, 8'h3A);
      chk("R10 wake on apply", n_wake, 1);
   endtask

   task automatic t_both();
      clr_counts();
      send(4'b1001, 8'h5B, 4'h0);
      chk("R5 both 1001 input", input_code, 8'h5B);
      chk("R5 both 1001 dac", dac_code, 8'h5B);
      send(4'b1111, 8'hE1, 4'h0);
      chk("R5 both 1111 input", input_code, 8'hE1);
      chk("R5 both 1111 dac", dac_code, 8'hE1);
      chk("R10 wake on load both", n_wake, 2);
   endtask

   task automatic t_ignored();
      clr_counts();
      send(4'b0000, 8'h11, 4'h0);
      send(4'b0010, 8'h22, 4'h0);
      send(4'b0111, 8'h33, 4'h0);
      send(4'b1010, 8'h44, 4'h0);
      send(4'b1011, 8'h55, 4'h0);
      chk("R6 input_code", input_code, 8'hE1);
      chk("R6 dac_code", dac_code, 8'hE1);
      chk("R6 no strobes", n_wake + n_pm + n_err, 0);
   endtask

   task automatic t_length();
      clr_counts();
      open_frame();
      shift_bits({16'h0, 4'b1001, 8'h99, 4'h0}, 15);
      close_frame();
      chk("R7 short frame input", input_code, 8'hE1);
      chk("R7 short frame dac", dac_code, 8'hE1);
      open_frame();
      shift_bits({15'h0, 1'b1, 4'b1001, 8'h77, 4'h0}, 17);
      close_frame();
      chk("R7 long frame input", input_code, 8'hE1);
      chk("R7 long frame dac", dac_code, 8'hE1);
      chk("R7 no strobes", n_wake + n_pm + n_err, 0);
   endtask

   task automatic t_sub();
      clr_counts();
      send(4'b1001, 8'h66, 4'h4);
      chk("R8 input kept", input_code, 8'hE1);
      chk("R8 dac kept", dac_code, 8'hE1);
      chk("R8 one error pulse", n_err, 1);
      chk("R8 no wake", n_wake, 0);
   endtask

   task automatic t_power();
      clr_counts();
      send(4'b1100, 8'b1000_0000, 4'h0);
      chk("R9 standby pulses", n_pm, 1);
      chk("R9 standby req", pm_req, 0);
      chk("R9 standby ref", ref_sel, 2);
      send(4'b1101, 8'b0111_1111, 4'h0);
      chk("R9 normal pulses", n_pm, 2);
      chk("R9 normal req", pm_req, 1);
      chk("R9 normal ref", ref_sel, 1);
      send(4'b1110, 8'b1100_0000, 4'h0);
      chk("R9 shutdown pulses", n_pm, 3);
      chk("R9 shutdown req", pm_req, 2);
      chk("R9 shutdown ref", ref_sel, 3);
      chk("R9 registers kept", {input_code, dac_code}, 16'hE1E1);
      chk("R10 no wake on power cmd", n_wake, 0);
   endtask

   task automatic t_hold();
      clr_counts();
      open_frame();
      shift_bits({16'h0, 4'b0001, 8'h0F, 4'h0}, 16);
      wait_clk(20);
      chk("R11 no effect while select low", input_code, 8'hE1);
      close_frame();
      chk("R11 effect after select rise", input_code, 8'h0F);
      chk("R11 dac kept", dac_code, 8'hE1);
   endtask

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      t_reset();
      t_stage();
      t_apply();
      t_both();
      t_ignored();
      t_length();
      t_sub();
      t_power();
      t_hold();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule